// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block collects every interrupt cause of a serial port and turns them into one interrupt line and one identification byte for software. It holds the interrupt-enable value and a transmitter-empty pending flag. On each clock it takes the highest-priority enabled cause that is active and registers its identification code. It then drives a level interrupt from that registered code.

Five cause classes are ranked. From highest to lowest they are: receive line errors, receive character timeout, received data ready, transmit holding register empty, and modem-line change. The transmitter-empty pending flag changes as a side effect of host accesses. Writing the enable value sets or clears it. Writing the transmit holding register clears it. Reading the identification byte while it reports the transmitter-empty code also clears it. A drain event from the transmitter sets it.

The host bus decode, the shift registers, the FIFO storage and the baud generator all sit outside this block. Their state arrives here as plain level and strobe pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the enable readback is 0x00, `irq` is low and the identification byte reads 0x01.
- R2: When several causes are active and enabled, the reported code follows this order: line error over timeout, timeout over received data, received data over transmitter empty, and transmitter empty over modem change.
- R3: The identification byte low nibble is 0x6 for line error, 0xC for timeout, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem change, and 0x1 when nothing is pending.
- R4: A line-error cause needs enable bit 2 and at least one of `lsr_i` bits 1 to 4 (mask 0x1E). Bits 0, 5, 6 and 7 of `lsr_i` never raise it.
- R5: A received-data cause needs enable bit 0 and `data_ready_i`. In addition, either `fifo_en_i` is low or `rx_level_i` >= `rx_trig_i`.
- R6: A timeout cause needs enable bit 0 and `rx_timeout_i`.
- R7: A modem-change cause needs enable bit 3 and any bit of `msr_delta_i`.
- R8: An enable write stores only `ier_wdata_i[3:0]`. `ier_o` reads back with bits 7:4 zero.
- R9: An enable write sets the transmitter-empty pending flag when the written bit 1 is 1 and `thre_i` is high. Otherwise the write clears the flag. The flag reports as code 0x2 only while enable bit 1 is set.
- R10: A transmit holding write (`thr_wr_i`) clears the pending flag. It takes precedence over an enable write and over a drain event in the same cycle.
- R11: An identification read (`iir_rd_i`) while the registered code is 0x2 clears the pending flag. A read while another code is reported leaves the flag unchanged. A drain event in the same cycle takes precedence over the read clear.
- R12: A drain event (`tx_drained_i`) sets the pending flag when no transmit holding write or enable write occurs in the same cycle.
- R13: Identification byte bits 7:6 read 11 while `fifo_en_i` is high and 00 while it is low. Bits 5:4 read 0.
- R14: The code and `irq` are registered. `irq` is high exactly when the registered code is not 0x1, and it follows a cause change one clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification byte read strobe |
| tx_drained_i | input | 1 | Transmitter has emptied its holding stage |
| thre_i | input | 1 | Transmit holding register empty status |
| lsr_i | input | 8 | Line status byte |
| data_ready_i | input | 1 | Received data ready |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_level_i | input | LVL_W | Receive FIFO fill count |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| rx_timeout_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem status change bits |
| ier_o | output | 8 | Enable register readback |
| iir_o | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
The priority encoder is driven with vectors where every cause is active at once. Causes are then removed one level at a time, which shows whether each rank hides the ones below it. Each cause is also presented alone, once with its enable bit set and once with it clear. This separates a missing enable gate from a wrong code. Line-status bytes with only bits 0 and 5 to 7 set check the error mask. FIFO levels one below, equal to and one above the trigger, and the FIFO-disabled case, separate the threshold compare from the data-ready condition. Directed sequences exercise each event that sets or clears the transmitter-empty pending flag, including same-cycle collisions, and check the one-edge interrupt latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // request vector index: 0 is the highest priority
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MODEM   = 4;
  localparam int NUM_SRC     = 5;

  localparam logic [7:0] LINE_ERR_MASK = 8'h1E;

  function automatic irq_id_e src_to_id(input int idx);
    case (idx)
      SRC_LINE:    return ID_LINE;
      SRC_TIMEOUT: return ID_TIMEOUT;
      SRC_RXDATA:  return ID_RXDATA;
      SRC_THRE:    return ID_THRE;
      default:     return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [3:0]         ier_q,
  input  logic [7:0]         lsr_i,
  input  logic               data_ready_i,
  input  logic               fifo_en_i,
  input  logic [LVL_W-1:0]   rx_level_i,
  input  logic [LVL_W-1:0]   rx_trig_i,
  input  logic               rx_timeout_i,
  input  logic               thre_pend_i,
  input  logic [3:0]         msr_delta_i,
  output logic [NUM_SRC-1:0] req_o
);

  logic level_met;

  always_comb begin
    level_met = !fifo_en_i || (rx_level_i >= rx_trig_i);
    req_o              = '0;
    req_o[SRC_LINE]    = ier_q[2] && |(lsr_i & LINE_ERR_MASK);
    req_o[SRC_TIMEOUT] = ier_q[0] && rx_timeout_i;
    req_o[SRC_RXDATA]  = ier_q[0] && data_ready_i && level_met;
    req_o[SRC_THRE]    = ier_q[1] && thre_pend_i;
    req_o[SRC_MODEM]   = ier_q[3] && |msr_delta_i;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output irq_id_e       id_o
);

  logic [N:0] above;
  assign above[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] && !above[i];
    assign above[i+1]  = above[i] || req_i[i];
  end

  always_comb begin
    id_o = ID_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) id_o = src_to_id(i);
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R2
  grant_any_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |-> (|grant_o));

endmodule

// File: rtl/uart_irq_thre_pend.sv
module uart_irq_thre_pend
  import uart_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    thr_wr_i,
  input  logic    ier_wr_i,
  input  logic    ier_thre_en_i,
  input  logic    thre_i,
  input  logic    tx_drained_i,
  input  logic    iir_rd_i,
  input  irq_id_e code_q_i,
  output logic    pend_o
);

  always_ff @(posedge clk) begin
    if (rst)                                   pend_o <= 1'b0;
    else if (thr_wr_i)                         pend_o <= 1'b0;
    else if (ier_wr_i)                         pend_o <= ier_thre_en_i && thre_i;
    else if (tx_drained_i)                     pend_o <= 1'b1;
    else if (iir_rd_i && code_q_i == ID_THRE)  pend_o <= 1'b0;
  end

  // R10
  thr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> !pend_o);

  // R9
  ier_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_wr_i && !ier_thre_en_i) |=> !pend_o);

  // R12
  drain_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_drained_i && !thr_wr_i && !ier_wr_i) |=> pend_o);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             tx_drained_i,
  input  logic             thre_i,
  input  logic [7:0]       lsr_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic [3:0]       msr_delta_i,
  output logic [7:0]       ier_o,
  output logic [7:0]       iir_o,
  output logic             irq
);

  logic [3:0]         ier_q;
  logic               thre_pend;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  irq_id_e            id_next;
  irq_id_e            code_q;

  always_ff @(posedge clk) begin
    if (rst)           ier_q <= '0;
    else if (ier_wr_i) ier_q <= ier_wdata_i[3:0];
  end

  uart_irq_thre_pend u_pend (
    .clk           (clk),
    .rst           (rst),
    .thr_wr_i      (thr_wr_i),
    .ier_wr_i      (ier_wr_i),
    .ier_thre_en_i (ier_wdata_i[1]),
    .thre_i        (thre_i),
    .tx_drained_i  (tx_drained_i),
    .iir_rd_i      (iir_rd_i),
    .code_q_i      (code_q),
    .pend_o        (thre_pend)
  );

  uart_irq_src #(.LVL_W(LVL_W)) u_src (
    .ier_q        (ier_q),
    .lsr_i        (lsr_i),
    .data_ready_i (data_ready_i),
    .fifo_en_i    (fifo_en_i),
    .rx_level_i   (rx_level_i),
    .rx_trig_i    (rx_trig_i),
    .rx_timeout_i (rx_timeout_i),
    .thre_pend_i  (thre_pend),
    .msr_delta_i  (msr_delta_i),
    .req_o        (req)
  );

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .grant_o (grant),
    .id_o    (id_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= ID_NONE;
      irq    <= 1'b0;
    end else begin
      code_q <= id_next;
      irq    <= (id_next != ID_NONE);
    end
  end

  assign ier_o = {4'b0000, ier_q};
  assign iir_o = {{2{fifo_en_i}}, 2'b00, code_q};

  // R4
  line_err_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_q[2] && |(lsr_i & LINE_ERR_MASK)) |=> (iir_o[3:0] == 4'h6));

  // R14
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_q == 4'h0) |=> !irq);

  // R8
  ier_store_chk: assert property (@(posedge clk) disable iff (rst)
    ier_wr_i |=> (ier_o == {4'b0000, $past(ier_wdata_i[3:0])}));

  // R11
  rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (iir_rd_i && code_q != ID_THRE && !thr_wr_i && !ier_wr_i) |=> $stable(thre_pend) || thre_pend);

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ier_wr = 0, thr_wr = 0, iir_rd = 0, drained = 0, thre = 0;
  logic [7:0] ier_wd = 0, lsr = 0;
  logic dr = 0, fen = 0, tmo = 0;
  logic [LVL_W-1:0] lvl = 0, trg = 0;
  logic [3:0] dmsr = 0;
  logic [7:0] ier_rb, iir;
  logic irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W)) u_uart_irq_ident (
    .clk(clk), .rst(rst), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wd),
    .thr_wr_i(thr_wr), .iir_rd_i(iir_rd), .tx_drained_i(drained),
    .thre_i(thre), .lsr_i(lsr), .data_ready_i(dr), .fifo_en_i(fen),
    .rx_level_i(lvl), .rx_trig_i(trg), .rx_timeout_i(tmo),
    .msr_delta_i(dmsr), .ier_o(ier_rb), .iir_o(iir), .irq(irq)
  );

  // fields: ier thre lsr dr fen lvl trg tmo delta expected_iir
  localparam int VW = 4+1+8+1+1+5+5+1+4+8;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'hF,1'b1,8'h02,1'b1,1'b0,5'd0, 5'd0, 1'b1,4'h1,8'h06}, // R2 all active
    {4'hF,1'b1,8'h00,1'b1,1'b1,5'd3, 5'd4, 1'b1,4'h1,8'hCC}, // R2 timeout
    {4'hF,1'b1,8'h00,1'b1,1'b1,5'd4, 5'd4, 1'b0,4'h1,8'hC4}, // R5 level == trig
    {4'hF,1'b1,8'h00,1'b1,1'b1,5'd3, 5'd4, 1'b0,4'h1,8'hC2}, // R2 thre under rx
    {4'hF,1'b0,8'h00,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h8,8'h00}, // R7 modem
    {4'h0,1'b1,8'hFF,1'b1,1'b0,5'd0, 5'd0, 1'b1,4'hF,8'h01}, // R3 none enabled
    {4'h4,1'b0,8'hE1,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h0,8'h01}, // R4 mask
    {4'h4,1'b0,8'h10,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h0,8'h06}, // R4 break
    {4'hB,1'b0,8'h08,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h0,8'h01}, // R4 bit2 off
    {4'h1,1'b0,8'h00,1'b1,1'b0,5'd0, 5'd14,1'b0,4'h0,8'h04}, // R5 fifo off
    {4'h1,1'b0,8'h00,1'b0,1'b1,5'd14,5'd14,1'b0,4'h0,8'hC1}, // R5 no dr
    {4'h1,1'b0,8'h00,1'b1,1'b1,5'd15,5'd14,1'b0,4'h0,8'hC4}, // R5 above trig
    {4'h1,1'b0,8'h00,1'b0,1'b0,5'd0, 5'd0, 1'b1,4'h0,8'h0C}, // R6 timeout alone
    {4'h8,1'b0,8'h00,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h0,8'h01}, // R7 no delta
    {4'h2,1'b1,8'h00,1'b0,1'b1,5'd0, 5'd0, 1'b0,4'h0,8'hC2}, // R9 set, R13
    {4'h2,1'b0,8'h00,1'b0,1'b0,5'd0, 5'd0, 1'b0,4'h0,8'h01}  // R9 cleared
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wd = v; ier_wr = 1; tick(1); ier_wr = 0;
  endtask

  task automatic clear_inputs();
    lsr = 0; dr = 0; fen = 0; lvl = 0; trg = 0; tmo = 0; dmsr = 0; thre = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk("R1 ier", ier_rb, 8'h00);
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      thre = v[33]; lsr = v[32:25]; dr = v[24]; fen = v[23];
      lvl = v[22:18]; trg = v[17:13]; tmo = v[12]; dmsr = v[11:8];
      wr_ier({4'h0, v[37:34]});
      tick(1);
      chk("R2/R3 table iir", iir, v[7:0]);
      chk("R14 table irq", {7'b0, irq}, {7'b0, v[3:0] != 4'h1});
    end

    // R8 upper bits dropped
    clear_inputs();
    wr_ier(8'hF5);
    chk("R8 ier readback", ier_rb, 8'h05);

    // R14 latency: one edge after cause appears
    wr_ier(8'h01);
    tick(1);
    chk("R14 idle before", {7'b0, irq}, 8'h00);
    tmo = 1;
    tick(1);
    chk("R14 irq one edge", {7'b0, irq}, 8'h01);
    tmo = 0;
    tick(1);
    chk("R14 irq drops", {7'b0, irq}, 8'h00);

    // R10 THR write clears pending
    thre = 1; wr_ier(8'h02); tick(1);
    chk("R10 pre", iir, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0; tick(1);
    chk("R10 thr write clears", iir, 8'h01);

    // R12 drain sets
    drained = 1; tick(1); drained = 0; tick(1);
    chk("R12 drain sets", iir, 8'h02);

    // R11 read while THRE reported clears
    iir_rd = 1; tick(1); iir_rd = 0; tick(1);
    chk("R11 read clears", iir, 8'h01);

    // R10 THR write beats drain
    drained = 1; thr_wr = 1; tick(1); drained = 0; thr_wr = 0; tick(1);
    chk("R10 thr over drain", iir, 8'h01);

    // R11 read while another code shows keeps pending
    wr_ier(8'h03); dr = 1; tick(1);
    chk("R11 rx shown", iir, 8'h04);
    iir_rd = 1; tick(1); iir_rd = 0;
    dr = 0; tick(2);
    chk("R11 pending kept", iir, 8'h02);

    // R11 drain beats read clear
    iir_rd = 1; drained = 1; tick(1); iir_rd = 0; drained = 0; tick(1);
    chk("R11 drain over read", iir, 8'h02);

    // R9 enable write with bit1 set but thre low clears
    thre = 0; wr_ier(8'h02); tick(1);
    chk("R9 thre low clears", iir, 8'h01);

    // R13 fifo bits follow fifo enable
    fen = 1; tick(1);
    chk("R13 fifo on", iir, 8'hC1);
    fen = 0; tick(1);
    chk("R13 fifo off", iir, 8'h01);

    // R1 reset mid-run
    thre = 1; wr_ier(8'h0F); tick(1);
    rst = 1; tick(1); rst = 0; tick(1);
    chk("R1 reset ier", ier_rb, 8'h00);
    chk("R1 reset iir", iir, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule